// File: doc/BRIEF.md
# Card Slot DAT1 Interrupt Controller

This block serves two memory card slots. For each slot it watches the DAT1 line and raises an interrupt status bit while a card drives that line low. The status can only be raised while the slot is powered and not selected, and only after software has switched on that slot's interrupt function. Detection follows the level of DAT1. There is no edge detection, no debounce and no clock in the path. A status bit whose mask is clear drives the single shared interrupt pin. That pin is active high and has no register in its path.

Each slot has five lines: CMD and DAT3..DAT0. The block keeps a pull enable bit and a pull direction bit for every one of these lines and drives them out to the pad control. A simple synchronous write and combinational read port reaches all control bits. The same port also reads the raw DAT1 levels and the status bits.

Register map. Slot s is 0 or 1.

| Offset | Access | Contents |
|--------|--------|----------|
| s | read/write | Pull enable bits in bits 4..0, pull direction bits in bits 9..5. Bit n is line n, ordered DAT0, DAT1, DAT2, DAT3, CMD. |
| 2 | read/write | Interrupt function enables, bit s. |
| 3 | read-only | Raw DAT1 levels, bit s. |
| 4 | read/write | Masks, bit s. |
| 5 | read-only | Status bits, bit s. |
| 6, 7 | none | Read as 0. |

In the pull registers an enable bit of 1 turns the pull on. A direction bit of 0 selects pulldown and 1 selects pullup.

Top module: `card_irq_ctrl`

## Requirements
- R1: After reset all pull bits and both interrupt enables are 0, both masks (offset 4) are 1, and irq_o is 0.
- R2: A write to offset s (0 or 1) sets that slot's pull enable outputs to wdata bits 4..0 and its pull direction outputs to bits 9..5 on the next clock edge. A read of the offset returns the stored value.
- R3: Status bit s (offset 5, bit s) is 1 exactly when enable bit s is 1, pwr_i[s] is 1, sel_i[s] is 0 and dat1_i[s] is 0. It follows these inputs with no clock edge.
- R4: The status is level sensitive and holds nothing. It stays 1 for as long as DAT1 stays low and returns to 0 as soon as DAT1 goes high.
- R5: Writing 0 to enable bit s (offset 2) forces status bit s to 0 from the next clock edge on, whatever DAT1 does.
- R6: Offset 3, bit s always equals dat1_i[s], whatever the enable, mask, power and select state.
- R7: irq_o is the OR over both slots of (status bit s AND NOT mask bit s). A mask bit of 1 keeps that slot off irq_o.
- R8: Writes to the read-only offsets 3 and 5, and to the unmapped offsets 6 and 7, change no stored bit. Offsets 6 and 7 read as 0.
- R9: If pwr_i[s] falls or sel_i[s] rises, status bit s and its contribution to irq_o drop in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Read data, combinational from addr_i |
| pwr_i | input | 2 | Slot powered, one bit per slot |
| sel_i | input | 2 | Slot selected, one bit per slot |
| dat1_i | input | 2 | DAT1 line level, one bit per slot |
| pull_en_o | output | 10 | Pull enables; slot s in bits 5s+4..5s |
| pull_up_o | output | 10 | Pull directions (1 = pullup); slot s in bits 5s+4..5s |
| irq_o | output | 1 | Shared interrupt, active high |

## Verification
A register write to the enable or mask offset can land in the same cycle as a change of DAT1, power or select. The status path has no clock, while the enable and mask only change at the edge. The bench provokes these collisions with random writes to offsets 2 and 4, while it redraws the slot inputs every cycle and adds directed cases that disable a slot while its DAT1 is held low. It checks irq_o and the read-back status a moment after each input change and before the following edge. The expected values come from a bench model that applies a write only after the edge.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int unsigned SLOTS = 2;
  localparam int unsigned LINES = 5;
  localparam int unsigned ADDR_W = 3;
endpackage

// File: rtl/slot_pull_reg.sv
module slot_pull_reg #(
  parameter int unsigned NLINE = 5,
  localparam int unsigned DW = 2 * NLINE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NLINE-1:0] en_o,
  output logic [NLINE-1:0] up_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= '0;
      up_o <= '0;
    end else if (wr_i) begin
      en_o <= wdata_i[NLINE-1:0];
      up_o <= wdata_i[DW-1:NLINE];
    end
  end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int unsigned NSLOT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ien_i,
  input  logic             wr_msk_i,
  input  logic [NSLOT-1:0] wdata_i,
  output logic [NSLOT-1:0] ien_o,
  output logic [NSLOT-1:0] msk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o <= '0;
      msk_o <= '1;
    end else begin
      if (wr_ien_i) ien_o <= wdata_i;
      if (wr_msk_i) msk_o <= wdata_i;
    end
  end
endmodule

// File: rtl/slot_irq_gate.sv
// Level-sensitive, unclocked status gate for one slot.
module slot_irq_gate (
  input  logic ien_i,
  input  logic pwr_i,
  input  logic sel_i,
  input  logic dat1_i,
  input  logic msk_i,
  output logic stat_o,
  output logic req_o
);
  always_comb begin
    stat_o = ien_i & pwr_i & ~sel_i & ~dat1_i;
    req_o  = stat_o & ~msk_i;
  end
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
#(
  parameter int unsigned NSLOT = SLOTS,
  parameter int unsigned NLINE = LINES,
  parameter int unsigned AW    = ADDR_W,
  localparam int unsigned DW   = 2 * NLINE,
  localparam int unsigned PW   = NSLOT * NLINE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NSLOT-1:0] pwr_i,
  input  logic [NSLOT-1:0] sel_i,
  input  logic [NSLOT-1:0] dat1_i,
  output logic [PW-1:0]    pull_en_o,
  output logic [PW-1:0]    pull_up_o,
  output logic             irq_o
);
  localparam logic [AW-1:0] OFS_IEN = AW'(NSLOT);
  localparam logic [AW-1:0] OFS_RAW = AW'(NSLOT + 1);
  localparam logic [AW-1:0] OFS_MSK = AW'(NSLOT + 2);
  localparam logic [AW-1:0] OFS_OUT = AW'(NSLOT + 3);

  logic [NSLOT-1:0] ien_q, msk_q, stat, req;

  irq_ctl_regs #(.NSLOT(NSLOT)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ien_i (we_i && addr_i == OFS_IEN),
    .wr_msk_i (we_i && addr_i == OFS_MSK),
    .wdata_i  (wdata_i[NSLOT-1:0]),
    .ien_o    (ien_q),
    .msk_o    (msk_q)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    slot_pull_reg #(.NLINE(NLINE)) u_pull (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && addr_i == AW'(s)),
      .wdata_i (wdata_i),
      .en_o    (pull_en_o[s*NLINE +: NLINE]),
      .up_o    (pull_up_o[s*NLINE +: NLINE])
    );

    slot_irq_gate u_gate (
      .ien_i  (ien_q[s]),
      .pwr_i  (pwr_i[s]),
      .sel_i  (sel_i[s]),
      .dat1_i (dat1_i[s]),
      .msk_i  (msk_q[s]),
      .stat_o (stat[s]),
      .req_o  (req[s])
    );
  end

  assign irq_o = |req;

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (addr_i == AW'(s))
        rdata_o = {pull_up_o[s*NLINE +: NLINE], pull_en_o[s*NLINE +: NLINE]};
    end
    unique case (addr_i)
      OFS_IEN: rdata_o[NSLOT-1:0] = ien_q;
      OFS_RAW: rdata_o[NSLOT-1:0] = dat1_i;
      OFS_MSK: rdata_o[NSLOT-1:0] = msk_q;
      OFS_OUT: rdata_o[NSLOT-1:0] = stat;
      default: ;
    endcase
  end
endmodule

// File: rtl/card_irq_chk.sv
module card_irq_chk #(
  parameter int unsigned NSLOT = 2,
  parameter int unsigned NLINE = 5,
  parameter int unsigned AW    = 3,
  localparam int unsigned DW   = 2 * NLINE,
  localparam int unsigned PW   = NSLOT * NLINE
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [NSLOT-1:0] pwr_i,
  input logic [NSLOT-1:0] sel_i,
  input logic [NSLOT-1:0] dat1_i,
  input logic [PW-1:0]    pull_en_o,
  input logic             irq_o,
  input logic [NSLOT-1:0] ien_q,
  input logic [NSLOT-1:0] msk_q
);
  // R9
  no_eligible_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pwr_i & ~sel_i & ~dat1_i)) |-> !irq_o);
  // R7
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk_q) |-> !irq_o);
  // R5
  disable_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(NSLOT) && wdata_i[NSLOT-1:0] == '0) |=> !irq_o);
  // R2
  pull_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> pull_en_o[NLINE-1:0] == $past(wdata_i[NLINE-1:0]));
  // R8
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == AW'(NSLOT + 1) || addr_i == AW'(NSLOT + 3)))
      |=> $stable(ien_q) && $stable(msk_q));
endmodule

bind card_irq_ctrl card_irq_chk #(.NSLOT(NSLOT), .NLINE(NLINE), .AW(AW)) u_chk (.*);

// File: tb/tb_card_irq_ctrl.sv
`timescale 1ns/1ps
module tb_card_irq_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [9:0] wdata_i = '0, rdata_o, pull_en_o, pull_up_o;
  logic [1:0] pwr_i = '0, sel_i = '0, dat1_i = 2'b11;
  logic       irq_o;

  card_irq_ctrl dut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // bench model
  logic [4:0] m_en [2], m_up [2];
  logic [1:0] m_ien, m_msk;

  function automatic logic [1:0] f_stat();
    return m_ien & pwr_i & ~sel_i & ~dat1_i;
  endfunction

  function automatic logic [9:0] f_rd(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return {m_up[a[0]], m_en[a[0]]};
      3'd2: return {8'h0, m_ien};
      3'd3: return {8'h0, dat1_i};
      3'd4: return {8'h0, m_msk};
      3'd5: return {8'h0, f_stat()};
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [2:0] a, logic [9:0] wd,
                      logic [1:0] pw, logic [1:0] sl, logic [1:0] d1);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = wd; pwr_i = pw; sel_i = sl; dat1_i = d1;
    #0.5;
    chk({tag, " irq"}, 32'(irq_o), 32'(|(f_stat() & ~m_msk)));
    chk({tag, " rdata"}, 32'(rdata_o), 32'(f_rd(a)));
    chk({tag, " pulls"}, {12'h0, pull_up_o, pull_en_o},
        {12'h0, m_up[1], m_up[0], m_en[1], m_en[0]});
    if (we) begin
      case (a)
        3'd0, 3'd1: begin m_en[a[0]] = wd[4:0]; m_up[a[0]] = wd[9:5]; end
        3'd2: m_ien = wd[1:0];
        3'd4: m_msk = wd[1:0];
        default: ;
      endcase
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    m_en[0] = '0; m_en[1] = '0; m_up[0] = '0; m_up[1] = '0;
    m_ien = '0; m_msk = 2'b11;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    step("R1", 0, 3'd4, 0, 2'b11, 2'b00, 2'b00);
    chk("R1 mask reset", 32'(rdata_o), 32'h3);
    step("R1", 0, 3'd2, 0, 2'b11, 2'b00, 2'b00);
    chk("R1 enable reset", 32'(rdata_o), 0);
    // R2 pull registers
    step("R2", 1, 3'd0, 10'h2a5, 2'b00, 2'b00, 2'b11);
    step("R2", 1, 3'd1, 10'h15a, 2'b00, 2'b00, 2'b11);
    step("R2", 0, 3'd0, 0, 2'b00, 2'b00, 2'b11);
    chk("R2 slot0 readback", 32'(rdata_o), 32'h2a5);
    step("R2", 0, 3'd1, 0, 2'b00, 2'b00, 2'b11);
    // R3 enable both, unmask
    step("R3", 1, 3'd2, 10'h3, 2'b11, 2'b00, 2'b11);
    step("R7", 1, 3'd4, 10'h0, 2'b11, 2'b00, 2'b11);
    step("R3", 0, 3'd5, 0, 2'b11, 2'b00, 2'b11);
    chk("R3 idle no irq", 32'(irq_o), 0);
    // R3/R4 DAT1 low then high, no clock needed
    step("R3", 0, 3'd5, 0, 2'b11, 2'b00, 2'b10);
    chk("R3 slot0 status", 32'(rdata_o), 32'h1);
    chk("R3 irq raised", 32'(irq_o), 1);
    step("R4", 0, 3'd5, 0, 2'b11, 2'b00, 2'b10);
    chk("R4 level held", 32'(irq_o), 1);
    step("R4", 0, 3'd5, 0, 2'b11, 2'b00, 2'b11);
    chk("R4 released", 32'(irq_o), 0);
    // R9 power and select gate immediately
    step("R9", 0, 3'd5, 0, 2'b10, 2'b00, 2'b10);
    chk("R9 unpowered", 32'(irq_o), 0);
    step("R9", 0, 3'd5, 0, 2'b11, 2'b01, 2'b10);
    chk("R9 selected", 32'(irq_o), 0);
    // R7 mask slot1 only, slot1 low
    step("R7", 1, 3'd4, 10'h2, 2'b11, 2'b00, 2'b01);
    step("R7", 0, 3'd5, 0, 2'b11, 2'b00, 2'b01);
    chk("R7 masked status visible", 32'(rdata_o), 32'h2);
    chk("R7 masked irq", 32'(irq_o), 0);
    // R6 raw mirror regardless of gating
    step("R6", 0, 3'd3, 0, 2'b00, 2'b11, 2'b10);
    chk("R6 raw", 32'(rdata_o), 32'h2);
    // R5 disable while DAT1 low, collision with DAT1 change
    step("R5", 1, 3'd4, 10'h0, 2'b11, 2'b00, 2'b00);
    step("R5", 1, 3'd2, 10'h0, 2'b11, 2'b00, 2'b00);
    step("R5", 0, 3'd5, 0, 2'b11, 2'b00, 2'b00);
    chk("R5 disabled", 32'(irq_o), 0);
    // R8 read-only and unmapped writes
    step("R8", 1, 3'd3, 10'h3ff, 2'b11, 2'b00, 2'b00);
    step("R8", 1, 3'd5, 10'h3ff, 2'b11, 2'b00, 2'b00);
    step("R8", 1, 3'd6, 10'h3ff, 2'b11, 2'b00, 2'b00);
    step("R8", 1, 3'd7, 10'h3ff, 2'b11, 2'b00, 2'b00);
    step("R8", 0, 3'd2, 0, 2'b11, 2'b00, 2'b00);
    chk("R8 enable untouched", 32'(rdata_o), 0);
    step("R8", 0, 3'd6, 0, 2'b11, 2'b00, 2'b00);
    chk("R8 unmapped", 32'(rdata_o), 0);
    // random mix, biased toward enable/mask writes
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      a = ($urandom % 3 == 0) ? 3'(2 + 2 * ($urandom % 2)) : 3'($urandom % 8);
      step("R7 random", 1'($urandom % 2), a, 10'($urandom),
           2'($urandom), 2'($urandom), 2'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule